// File: doc/BRIEF.md
# Stereo Transmit Sample FIFO with Underrun Hold

This block sits between a host that produces audio samples and a serial audio transmitter. It keeps two independent first-in first-out queues, one for the left channel and one for the right. The host writes samples into either queue. Once per frame slot the transmitter raises a single pull strobe, and each channel then presents its oldest queued sample on its output register.

When a channel's queue is empty at a pull, that channel keeps presenting the last sample it sent. It also sets a sticky underrun status bit. Once the host writes a fresh sample, the next pull presents that sample. An interrupt line is the OR of the two underrun bits. The host clears an underrun bit by writing a one to its position in the clear word. A live not-full flag per channel lets the host fill each queue by polling. The not-full flag never raises the interrupt.

Top module: `stereo_tx_fifo`

## Requirements
- R1: After reset both channel outputs are 0, both not-full flags are 1, both underrun bits are 0 and the interrupt is 0.
- R2: A pull while a channel holds data makes that channel's output show its oldest queued sample on the next cycle, so samples leave in the order they were written.
- R3: A pull while a channel's queue is empty leaves that channel's output unchanged and sets that channel's underrun bit on the next cycle.
- R4: After an underrun, a newly written sample does not appear on the output until a later pull, and that pull presents it.
- R5: A channel's not-full flag is 0 exactly while its queue holds DEPTH (default 8) samples, and 1 otherwise.
- R6: A write to a full queue is dropped: draining afterwards yields only the DEPTH earlier samples and then an underrun.
- R7: Underrun bits are sticky. A clear write with bit 0 set clears the left bit and a clear write with bit 1 set clears the right bit. A clear write with a zero in a position leaves that bit unchanged. Status bit 0 is left and bit 1 is right.
- R8: The interrupt is 1 exactly when at least one underrun bit is 1. A full queue or a not-full flag never drives it.
- R9: The two channels are independent: writes, fill level and underrun in one never change the other's output, flag or status bit.
- R10: When an underrun set and a clear of the same bit fall in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrLeft | input | 1 | Write strobe for the left queue |
| hostWrRight | input | 1 | Write strobe for the right queue |
| leftWrData | input | DATA_W | Sample written to the left queue |
| rightWrData | input | DATA_W | Sample written to the right queue |
| slotPull | input | 1 | Frame-slot strobe; pulls one sample per channel |
| clrWr | input | 1 | Status-clear write strobe |
| clrData | input | 2 | Write-one-to-clear mask (bit 0 left, bit 1 right) |
| leftOut | output | DATA_W | Left sample presented to the transmitter |
| rightOut | output | DATA_W | Right sample presented to the transmitter |
| leftNotFull | output | 1 | Left queue has at least one free entry |
| rightNotFull | output | 1 | Right queue has at least one free entry |
| underrunSts | output | 2 | Sticky underrun bits (bit 0 left, bit 1 right) |
| irq | output | 1 | OR of the underrun bits |

## Verification
The bench fills a queue to exactly DEPTH and writes once more. A design that accepted that write would corrupt a slot or present an extra sample during the drain. It pulls from an empty queue and checks that the output repeats the last sample instead of dropping to zero or showing stale storage. It also checks that a sample written after the underrun waits for the next pull. It clears status with a zero mask, with a single bit, and in the same cycle as a fresh underrun. A design that cleared on any write, or let the clear win, would lose the sticky bit. Running one channel while the other sits idle or empty exposes any cross-coupling of flags or status between the channels.

// File: rtl/stereo_tx_pkg.sv
package stereo_tx_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_LEFT = 0;
  localparam int CH_RIGHT = 1;

  typedef struct packed {
    logic push;
    logic pop;
    logic setUnderrun;
  } chanStrobeT;
endpackage

// File: rtl/stereo_tx_ctrl.sv
module stereo_tx_ctrl
  import stereo_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   wrReq,
  input  logic                slotPull,
  input  logic                clrWr,
  input  logic [NUM_CH-1:0]   clrData,
  input  logic [NUM_CH-1:0]   chanEmpty,
  input  logic [NUM_CH-1:0]   chanFull,
  output chanStrobeT          chanStrb [NUM_CH],
  output logic [NUM_CH-1:0]   underrunSts,
  output logic                irq
);
  logic [NUM_CH-1:0] setMask;
  logic [NUM_CH-1:0] clrMask;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      chanStrb[i].push        = wrReq[i] & ~chanFull[i];
      chanStrb[i].pop         = slotPull & ~chanEmpty[i];
      chanStrb[i].setUnderrun = slotPull & chanEmpty[i];
      setMask[i]              = chanStrb[i].setUnderrun;
    end
  end

  assign clrMask = clrWr ? clrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) underrunSts <= '0;
    else       underrunSts <= (underrunSts & ~clrMask) | setMask;
  end

  assign irq = |underrunSts;
endmodule

// File: rtl/stereo_tx_dpath.sv
module stereo_tx_dpath
  import stereo_tx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobeT        chanStrb [NUM_CH],
  input  logic [DATA_W-1:0] wrData   [NUM_CH],
  output logic [DATA_W-1:0] sampleOut[NUM_CH],
  output logic [NUM_CH-1:0] chanEmpty,
  output logic [NUM_CH-1:0] chanFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] holdReg;

    always_ff @(posedge clk) begin
      if (chanStrb[ch].push) mem[wrPtr] <= wrData[ch];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        count   <= '0;
        holdReg <= '0;
      end else begin
        if (chanStrb[ch].push)
          wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
        if (chanStrb[ch].pop) begin
          rdPtr   <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
          holdReg <= mem[rdPtr];
        end
        case ({chanStrb[ch].push, chanStrb[ch].pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end

    assign chanEmpty[ch] = (count == '0);
    assign chanFull[ch]  = (count == FULL_CNT);
    assign sampleOut[ch] = holdReg;
  end
endmodule

// File: rtl/stereo_tx_fifo.sv
module stereo_tx_fifo
  import stereo_tx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrLeft,
  input  logic              hostWrRight,
  input  logic [DATA_W-1:0] leftWrData,
  input  logic [DATA_W-1:0] rightWrData,
  input  logic              slotPull,
  input  logic              clrWr,
  input  logic [1:0]        clrData,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut,
  output logic              leftNotFull,
  output logic              rightNotFull,
  output logic [1:0]        underrunSts,
  output logic              irq
);
  chanStrobeT        chanStrb [NUM_CH];
  logic [DATA_W-1:0] wrData   [NUM_CH];
  logic [DATA_W-1:0] sampleOut[NUM_CH];
  logic [NUM_CH-1:0] chanEmpty;
  logic [NUM_CH-1:0] chanFull;
  logic [NUM_CH-1:0] wrReq;

  assign wrReq[CH_LEFT]   = hostWrLeft;
  assign wrReq[CH_RIGHT]  = hostWrRight;
  assign wrData[CH_LEFT]  = leftWrData;
  assign wrData[CH_RIGHT] = rightWrData;

  stereo_tx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrReq      (wrReq),
    .slotPull   (slotPull),
    .clrWr      (clrWr),
    .clrData    (clrData),
    .chanEmpty  (chanEmpty),
    .chanFull   (chanFull),
    .chanStrb   (chanStrb),
    .underrunSts(underrunSts),
    .irq        (irq)
  );

  stereo_tx_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .chanStrb (chanStrb),
    .wrData   (wrData),
    .sampleOut(sampleOut),
    .chanEmpty(chanEmpty),
    .chanFull (chanFull)
  );

  assign leftOut      = sampleOut[CH_LEFT];
  assign rightOut     = sampleOut[CH_RIGHT];
  assign leftNotFull  = ~chanFull[CH_LEFT];
  assign rightNotFull = ~chanFull[CH_RIGHT];
endmodule

// File: rtl/stereo_tx_fifo_chk.sv
module stereo_tx_fifo_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              slotPull,
  input logic              hostWrLeft,
  input logic              clrWr,
  input logic [1:0]        clrData,
  input logic [DATA_W-1:0] leftOut,
  input logic              leftNotFull,
  input logic [1:0]        underrunSts,
  input logic              irq,
  input logic              leftEmpty
);
  assert_empty_pull_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    slotPull && leftEmpty |=> underrunSts[0]);

  assert_empty_pull_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    slotPull && leftEmpty |=> $stable(leftOut));

  assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (!rstN)
    !leftNotFull && hostWrLeft && !slotPull |=> !leftNotFull);

  assert_sticky_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrunSts[0] && !(clrWr && clrData[0]) |=> underrunSts[0]);

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrWr && clrData[0] && !(slotPull && leftEmpty) |=> !underrunSts[0]);

  assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(slotPull));
endmodule

bind stereo_tx_fifo stereo_tx_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .slotPull   (slotPull),
  .hostWrLeft (hostWrLeft),
  .clrWr      (clrWr),
  .clrData    (clrData),
  .leftOut    (leftOut),
  .leftNotFull(leftNotFull),
  .underrunSts(underrunSts),
  .irq        (irq),
  .leftEmpty  (chanEmpty[0])
);

// File: tb/stereo_tx_fifo_tb.sv
module stereo_tx_fifo_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              hostWrLeft, hostWrRight;
  logic [DATA_W-1:0] leftWrData, rightWrData;
  logic              slotPull, clrWr;
  logic [1:0]        clrData;
  logic [DATA_W-1:0] leftOut, rightOut;
  logic              leftNotFull, rightNotFull, irq;
  logic [1:0]        underrunSts;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stereo_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN),
    .hostWrLeft(hostWrLeft), .hostWrRight(hostWrRight),
    .leftWrData(leftWrData), .rightWrData(rightWrData),
    .slotPull(slotPull), .clrWr(clrWr), .clrData(clrData),
    .leftOut(leftOut), .rightOut(rightOut),
    .leftNotFull(leftNotFull), .rightNotFull(rightNotFull),
    .underrunSts(underrunSts), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    hostWrLeft = 0; hostWrRight = 0; slotPull = 0; clrWr = 0; clrData = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic pushL(input logic [DATA_W-1:0] v);
    hostWrLeft = 1; leftWrData = v; step();
  endtask

  task automatic pushR(input logic [DATA_W-1:0] v);
    hostWrRight = 1; rightWrData = v; step();
  endtask

  task automatic pull();
    slotPull = 1; step();
  endtask

  task automatic clearSts(input logic [1:0] m);
    clrWr = 1; clrData = m; step();
  endtask

  task automatic t_reset();
    check("R1 leftOut", 32'(leftOut), 0);
    check("R1 rightOut", 32'(rightOut), 0);
    check("R1 notFull", {30'd0, leftNotFull, rightNotFull}, 3);
    check("R1 status", 32'(underrunSts), 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_order();
    pushL(16'h1111); pushL(16'h2222); pushR(16'hA0A0);
    pull();
    check("R2 left first", 32'(leftOut), 32'h1111);
    check("R2 right first", 32'(rightOut), 32'hA0A0);
    check("R9 no underrun yet", 32'(underrunSts), 0);
    pull();
    check("R2 left second", 32'(leftOut), 32'h2222);
    check("R3 right held", 32'(rightOut), 32'hA0A0);
    check("R9 only right underrun", 32'(underrunSts), 2);
    check("R8 irq on", 32'(irq), 1);
  endtask

  task automatic t_clear();
    clearSts(2'b00);
    check("R7 zero mask keeps", 32'(underrunSts), 2);
    clearSts(2'b01);
    check("R7 other bit keeps", 32'(underrunSts), 2);
    clearSts(2'b10);
    check("R7 right cleared", 32'(underrunSts), 0);
    check("R8 irq off", 32'(irq), 0);
  endtask

  task automatic t_hold();
    pull();
    check("R3 left held", 32'(leftOut), 32'h2222);
    check("R3 left underrun", 32'(underrunSts[0]), 1);
    pull();
    check("R3 still held", 32'(leftOut), 32'h2222);
    pushL(16'h3333);
    check("R4 waits for pull", 32'(leftOut), 32'h2222);
    pull();
    check("R4 new sample used", 32'(leftOut), 32'h3333);
    clearSts(2'b11);
    check("R7 both cleared", 32'(underrunSts), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) check("R5 notFull before last", 32'(leftNotFull), 1);
      pushL(16'h0100 + 16'(i));
    end
    check("R5 full flag", 32'(leftNotFull), 0);
    check("R9 right not full", 32'(rightNotFull), 1);
    check("R8 full no irq", 32'(irq), 0);
    pushL(16'hDEAD);
    check("R6 still full", 32'(leftNotFull), 0);
    for (int i = 0; i < DEPTH; i++) begin
      pull();
      check("R6 drain order", 32'(leftOut), 32'h0100 + i);
      if (i == 0) check("R5 notFull after pull", 32'(leftNotFull), 1);
    end
    check("R6 no left underrun yet", 32'(underrunSts[0]), 0);
    pull();
    check("R6 dropped write absent", 32'(leftOut), 32'h0107);
    check("R6 underrun after drain", 32'(underrunSts[0]), 1);
    clearSts(2'b11);
  endtask

  task automatic t_setwins();
    slotPull = 1; clrWr = 1; clrData = 2'b01; step();
    check("R10 set beats clear", 32'(underrunSts[0]), 1);
    clearSts(2'b11);
    check("R7 final clear", 32'(underrunSts), 0);
  endtask

  initial begin
    idle();
    leftWrData = 0; rightWrData = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_clear();
    t_hold();
    t_full();
    t_setwins();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule